// File: doc/BRIEF.md
# Two-Stage Prescaled PWM Generator

This block produces one pulse-width-modulated output from a single clock. Two counters are chained: a prescale counter divides the clock, and each time it wraps, a period counter advances by one. The output period is therefore the product of two 16-bit divide ratios. A high-time compare against the period counter sets the duty cycle. Software controls the block through a two-word register port with a combinational read path.

The divide and high-time settings are double buffered. Writes land in shadow copies and have no effect on the waveform. A commit flag moves all three shadow values into the active copies together. The move happens at the next period boundary while the generator runs, or on the next clock while it is stopped. The commit flag clears itself once the move is done, and an enable flag starts and stops the output.

The generator has two states. `S_OFF` holds both counters at zero and the output low. While the enable flag is clear it stays in `S_OFF`. When the enable flag is set it takes the *start* transition to `S_RUN`, where the counters advance and the compare drives the output. It stays in `S_RUN` while the flag remains set. Clearing the flag takes the *stop* transition back to `S_OFF`.

Top module: `pwm2_gen`

## Requirements
- R1: After reset the output is low, and both registers read as all zeros.
- R2: Register 0 (address 0) holds the period divide value in bits [15:0] and the high time in bits [31:16]. A read of register 0 returns the last written (shadow) values.
- R3: Register 1 (address 1) holds the prescale value in bits [15:0], the commit flag in bit 30 and the enable flag in bit 31. Bits [29:16] read as zero.
- R4: While running, the output period is (prescale + 1) × (period divide + 1) clocks.
- R5: Within a period, the period counter counts 0 to the period divide value and advances once every prescale + 1 clocks. The output is high while this counter is below the active high time and low otherwise. A high time of 0 keeps the output low for the whole period. A high time above the period divide value keeps it high for the whole period.
- R6: Writing shadow values without the commit flag leaves the running waveform unchanged.
- R7: A pending commit copies the shadow values to the active copies at the clock edge that ends the current period, and the next period uses the new values. While the generator is stopped, the copy happens on the next clock.
- R8: The commit flag reads back as 1 while a copy is pending and as 0 after the copy.
- R9: The output is low from the clock after the enable flag clears. On re-enable both counters restart from zero, so the first output cycle is the first cycle of a period.
- R10: Setting the enable flag without the commit flag runs with the active values already in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 or 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check invariants on every cycle:
- both counters stay within their active limits;
- the active copies change only on a commit;
- the commit flag drops after a transfer;
- the enable flag follows each write;
- the output goes low one clock after the enable flag clears.

Only the bench scenarios can show the following:
- the exact waveform over whole periods;
- the cycle at which a commit takes effect relative to the period boundary;
- that shadow writes leave the running output alone;
- the high-time edge cases of zero and above the period.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int REG_W    = 32;
    localparam int UPD_BIT  = 30;
    localparam int EN_BIT   = 31;

    typedef enum logic {
        S_OFF = 1'b0,
        S_RUN = 1'b1
    } pwm_state_e;

endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              take,
    output logic [CNT_W-1:0]  sh_pre,
    output logic [CNT_W-1:0]  sh_div,
    output logic [CNT_W-1:0]  sh_hi,
    output logic              en,
    output logic              upd_pend
);

    localparam int HI_LO = CNT_W;
    localparam int HI_HI = 2 * CNT_W - 1;

    logic wr0, wr1;

    assign wr0 = reg_we && !reg_addr;
    assign wr1 = reg_we &&  reg_addr;

    // Register 0 shadow fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div <= '0;
            sh_hi  <= '0;
        end else if (wr0) begin
            sh_div <= reg_wdata[CNT_W-1:0];
            sh_hi  <= reg_wdata[HI_HI:HI_LO];
        end
    end

    // Register 1: prescale, enable, commit flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre   <= '0;
            en       <= 1'b0;
            upd_pend <= 1'b0;
        end else begin
            if (wr1) begin
                sh_pre <= reg_wdata[CNT_W-1:0];
                en     <= reg_wdata[EN_BIT];
            end
            upd_pend <= (upd_pend && !take) || (wr1 && reg_wdata[UPD_BIT]);
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[CNT_W-1:0] = sh_pre;
            reg_rdata[UPD_BIT]   = upd_pend;
            reg_rdata[EN_BIT]    = en;
        end else begin
            reg_rdata[CNT_W-1:0]   = sh_div;
            reg_rdata[HI_HI:HI_LO] = sh_hi;
        end
    end

    // R8: a completed transfer drops the pending flag unless a new commit arrives
    a_r8_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(wr1 && reg_wdata[UPD_BIT])) |=> !upd_pend);

    // R3: enable flag follows every register 1 write
    a_r3_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr1 |=> (en == $past(reg_wdata[EN_BIT])));

endmodule

// File: rtl/pwm2_core.sv
module pwm2_core
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              upd_pend,
    input  logic [CNT_W-1:0]  sh_pre,
    input  logic [CNT_W-1:0]  sh_div,
    input  logic [CNT_W-1:0]  sh_hi,
    output logic              take,
    output logic              pwm_out
);

    localparam logic [CNT_W-1:0] ONE = 1;

    pwm_state_e state_q, state_d;

    logic [CNT_W-1:0] pre_q, per_q;
    logic [CNT_W-1:0] act_pre, act_div, act_hi;
    logic             pre_end, per_end, bound;

    assign pre_end = (pre_q == act_pre);
    assign per_end = (per_q == act_div);
    assign bound   = (state_q == S_OFF) || (pre_end && per_end);
    assign take    = upd_pend && bound;

    // Next-state logic
    always_comb begin
        unique case (state_q)
            S_OFF:   state_d = en ? S_RUN : S_OFF;
            S_RUN:   state_d = en ? S_RUN : S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Chained counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (state_q == S_OFF || state_d == S_OFF) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (pre_end) begin
            pre_q <= '0;
            per_q <= per_end ? '0 : per_q + ONE;
        end else begin
            pre_q <= pre_q + ONE;
        end
    end

    // Active copies, loaded on commit at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre <= '0;
            act_div <= '0;
            act_hi  <= '0;
        end else if (take) begin
            act_pre <= sh_pre;
            act_div <= sh_div;
            act_hi  <= sh_hi;
        end
    end

    // Output compare
    always_comb begin
        unique case (state_q)
            S_RUN:   pwm_out = (per_q < act_hi);
            default: pwm_out = 1'b0;
        endcase
    end

    // R4: counters never pass their active limits while running
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (pre_q <= act_pre && per_q <= act_div));

    // R6: active values hold unless a transfer happens
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(act_pre) && $stable(act_div) && $stable(act_hi)));

    // R9: output is low on the clock after enable clears
    a_r9_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

endmodule

// File: rtl/pwm2_gen.sv
module pwm2_gen
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              pwm_out
);

    logic [CNT_W-1:0] sh_pre, sh_div, sh_hi;
    logic             en, upd_pend, take;

    pwm2_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .take      (take),
        .sh_pre    (sh_pre),
        .sh_div    (sh_div),
        .sh_hi     (sh_hi),
        .en        (en),
        .upd_pend  (upd_pend)
    );

    pwm2_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .upd_pend (upd_pend),
        .sh_pre   (sh_pre),
        .sh_div   (sh_div),
        .sh_hi    (sh_hi),
        .take     (take),
        .pwm_out  (pwm_out)
    );

endmodule

// File: tb/pwm2_gen_test.sv
`timescale 1ns/100ps
module pwm2_gen_test;

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];
    bit    mon_e;
    string mon_t;

    always #2.5 clk = ~clk;

    pwm2_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a posedge; the write is captured at the next edge,
    // and the task returns 1 ns after that edge.
    task automatic wr(input logic addr, input logic [31:0] data);
        reg_we    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic addr, input logic [31:0] exp, input string tag);
        reg_addr = addr;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Driver side of the scoreboard: expected output, one item per clock
    task automatic push_pat(input int pre, input int div, input int hi,
                            input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            int per;
            per = (c % ((pre + 1) * (div + 1))) / (pre + 1);
            exp_q.push_back(per < hi);
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_off(input string tag);
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(posedge clk);
        #1;
    endtask

    task automatic stop_and_check();
        wr(1'b1, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 output low after disable", {31'b0, pwm_out}, 32'h0);
        end
        @(posedge clk);
        #1;
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            check(mon_t, {31'b0, pwm_out}, {31'b0, mon_e});
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1 output low", {31'b0, pwm_out}, 32'h0);
        rd(1'b0, 32'h0, "R1 reg0 zero");
        rd(1'b1, 32'h0, "R1 reg1 zero");
        @(posedge clk);
        #1;

        // Config A, then a shadow write, then a commit to config B mid-period
        wr(1'b0, {16'd2, 16'd3});
        wr(1'b1, EN | UPD | 32'd1);
        push_off("R9 first cycle off");
        push_pat(1, 3, 2, 16, "R4 R5 R6 config A");
        push_pat(0, 4, 3, 15, "R7 config B after boundary");
        rd(1'b1, 32'hC000_0001, "R8 pending before transfer");
        repeat (4) @(posedge clk);
        #1;
        wr(1'b0, {16'd3, 16'd4});
        rd(1'b0, 32'h0003_0004, "R2 shadow readback");
        repeat (5) @(posedge clk);
        #1;
        wr(1'b1, EN | UPD);
        rd(1'b1, 32'hC000_0000, "R8 pending flag set");
        drain();
        rd(1'b1, 32'h8000_0000, "R8 flag clear after transfer");

        stop_and_check();

        // Enable without commit keeps config B
        wr(1'b0, {16'd1, 16'd1});
        rd(1'b0, 32'h0001_0001, "R2 shadow readback");
        wr(1'b1, EN);
        push_off("R10 first cycle off");
        push_pat(0, 4, 3, 10, "R10 active values kept");
        drain();
        stop_and_check();

        // High time zero
        wr(1'b0, {16'd0, 16'd2});
        wr(1'b1, EN | UPD | 32'd1);
        push_off("R5 first cycle off");
        push_pat(1, 2, 0, 12, "R5 zero high time");
        drain();
        stop_and_check();

        // High time beyond the period
        wr(1'b0, {16'd5, 16'd2});
        wr(1'b1, EN | UPD);
        push_off("R5 first cycle off");
        push_pat(0, 2, 5, 9, "R5 high time above period");
        drain();
        stop_and_check();

        // Field limits, reserved bits, commit while stopped
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, 32'hFFFF_FFFF, "R2 full field values");
        wr(1'b1, 32'h7FFF_FFFF);
        rd(1'b1, 32'h4000_FFFF, "R3 reserved bits zero");
        @(posedge clk);
        #1;
        rd(1'b1, 32'h0000_FFFF, "R7 R8 transfer while stopped");
        check("R9 still low while stopped", {31'b0, pwm_out}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule